// File: doc/BRIEF.md
# Level-Persistence Noise Filter Timer

This block is a single timer channel that decides whether an external input has held a chosen level for long enough to be believed. Software picks which level counts as valid (high or low), programs a start count, and raises an enable bit. The input first passes through a two-flop synchronizer. While the synchronized input sits at the valid level, a 16-bit down-counter steps down once per count-clock enable pulse.

If the input drops to the invalid level, the counter freezes. When the input becomes valid again, the counter starts over from the programmed start count. If the counter runs past zero while the input is still valid, the block emits a one-cycle interrupt request and halts. It stays halted until software clears the enable bit and sets it again. Clearing the enable bit stops the channel at any time.

The block is meant to sit behind a register interface and a prescaler, which live elsewhere. The `tick` input is the prescaled count-clock enable.

Top module: `level_hold_timer`

## Requirements
- R1: After reset, `count` is 0, `irq` is 0 and `running` is 0.
- R2: In the cycle after `enable` goes from 0 to 1, `count` equals `reload_val` and `running` is 1.
- R3: The valid level is high when `valid_high` is 1 and low when `valid_high` is 0. The synchronized input counts as valid exactly when it equals `valid_high`.
- R4: `sig_in` passes through two flops before it is evaluated. After a change on `sig_in`, `running` does not react until the third clock edge.
- R5: While running at the valid level, `count` drops by exactly one on each edge where `tick` is 1, and it holds on edges where `tick` is 0.
- R6: While running, an invalid level makes `running` go to 0 (paused). While paused, `count` holds regardless of `tick`.
- R7: When the level becomes valid again after a pause, `count` is reloaded with `reload_val` and `running` returns to 1 on the same edge.
- R8: A `tick` while running at the valid level with `count` equal to 0 is an underflow. It produces `irq` = 1 and `running` = 0 on the next cycle, and `count` stays 0.
- R9: After an underflow, no further counting happens until `enable` is cleared and set again. That restart reloads `reload_val`.
- R10: While `enable` is 0, `running` and `irq` are 0 from the next cycle on, and `count` holds its value.
- R11: `irq` is high for exactly one cycle per underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Software enable; a rising edge arms the channel |
| valid_high | input | 1 | 1: high is the valid level, 0: low is the valid level |
| reload_val | input | 16 | Start count loaded on enable and on each return to the valid level |
| tick | input | 1 | Count-clock enable pulse |
| sig_in | input | 1 | Asynchronous external input under test |
| irq | output | 1 | One-cycle interrupt request on underflow |
| count | output | 16 | Current counter value |
| running | output | 1 | 1 while armed and counting at the valid level |

## Verification
Several rules are checked by assertions on every cycle:
- a single-step decrement on a tick at the valid level;
- no change of `count` without a tick;
- loading of `reload_val` on an enable rise;
- the single-cycle `irq`, which only follows a tick at zero;
- silence while disabled.

Some behaviour only the bench scenarios can show: the two-cycle synchronizer latency, the reload after a dropout, both level polarities, and the lock after self-stop until the enable bit is re-armed. The bench shows these by following a behavioural model through directed sequences and a long random stretch.

// File: rtl/lht_pkg.sv
package lht_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2,
        ST_DONE  = 2'd3
    } lht_state_e;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_cmd_e;

    function automatic logic level_matches(input logic sample, input logic pol);
        return sample == pol;
    endfunction

endpackage

// File: rtl/lht_sync.sv
module lht_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lht_counter.sv
module lht_counter
    import lht_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_cmd_e     cmd,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         zero
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else begin
            case (cmd)
                CNT_LOAD: value <= load_val;
                CNT_DEC:  value <= value - ONE;
                default:  value <= value;
            endcase
        end
    end

    assign zero = (value == '0);
endmodule

// File: rtl/lht_ctrl.sv
module lht_ctrl
    import lht_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       lvl_ok,
    input  logic       tick,
    input  logic       zero,
    output cnt_cmd_e   cmd,
    output lht_state_e state,
    output logic       irq
);
    lht_state_e nxt;
    logic       en_q;
    logic       en_rise;
    logic       fire;

    assign en_rise = enable & ~en_q;

    always_comb begin
        nxt  = state;
        cmd  = CNT_HOLD;
        fire = 1'b0;
        if (!enable) begin
            nxt = ST_OFF;
        end else if (en_rise) begin
            nxt = ST_RUN;
            cmd = CNT_LOAD;
        end else begin
            case (state)
                ST_RUN: begin
                    if (!lvl_ok) begin
                        nxt = ST_PAUSE;
                    end else if (tick) begin
                        if (zero) begin
                            nxt  = ST_DONE;
                            fire = 1'b1;
                        end else begin
                            cmd = CNT_DEC;
                        end
                    end
                end
                ST_PAUSE: begin
                    if (lvl_ok) begin
                        nxt = ST_RUN;
                        cmd = CNT_LOAD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
            en_q  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            state <= nxt;
            en_q  <= enable;
            irq   <= fire;
        end
    end
endmodule

// File: rtl/level_hold_timer.sv
module level_hold_timer
    import lht_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             valid_high,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  logic             sig_in,
    output logic             irq,
    output logic [CNT_W-1:0] count,
    output logic             running
);
    logic       sync_q;
    logic       lvl_ok;
    logic       zero;
    cnt_cmd_e   cmd;
    lht_state_e state;

    lht_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sig_in),
        .q   (sync_q)
    );

    assign lvl_ok = level_matches(sync_q, valid_high);

    lht_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .lvl_ok (lvl_ok),
        .tick   (tick),
        .zero   (zero),
        .cmd    (cmd),
        .state  (state),
        .irq    (irq)
    );

    lht_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (reload_val),
        .value    (count),
        .zero     (zero)
    );

    assign running = (state == ST_RUN);
endmodule

// File: rtl/lht_checker.sv
module lht_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             tick,
    input logic             lvl_ok,
    input logic [CNT_W-1:0] reload_val,
    input logic [CNT_W-1:0] count,
    input logic             irq,
    input logic             running
);
    AST_LOAD_ON_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(enable) |=> (count == $past(reload_val)) && running); // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (running && enable && lvl_ok && tick && count != '0) |=> count == $past(count) - CNT_W'(1)); // R5

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (running && !tick) |=> $stable(count)); // R5

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(running && tick && count == '0)); // R8

    AST_IRQ_HALTS: assert property (@(posedge clk) disable iff (rst)
        irq |-> !running && count == '0); // R8

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R11

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !running && !irq); // R10
endmodule

bind level_hold_timer lht_checker #(.CNT_W(CNT_W)) u_lht_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .tick       (tick),
    .lvl_ok     (lvl_ok),
    .reload_val (reload_val),
    .count      (count),
    .irq        (irq),
    .running    (running)
);

// File: tb/level_hold_timer_test.sv
module level_hold_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        valid_high = 1'b1;
    logic [15:0] reload_val = '0;
    logic        tick = 1'b0;
    logic        sig_in = 1'b0;
    logic        irq;
    logic [15:0] count;
    logic        running;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    level_hold_timer uut (
        .clk(clk), .rst(rst), .enable(enable), .valid_high(valid_high),
        .reload_val(reload_val), .tick(tick), .sig_in(sig_in),
        .irq(irq), .count(count), .running(running)
    );

    // behavioural reference: 0 off, 1 run, 2 pause, 3 done
    int m_s1, m_s2, m_enq, m_st, m_cnt, m_irq;

    always @(posedge clk) begin
        int ns, nc, ni;
        bit lv;
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_enq <= 0; m_st <= 0; m_cnt <= 0; m_irq <= 0;
        end else begin
            lv = (m_s2 == int'(valid_high));
            ns = m_st; nc = m_cnt; ni = 0;
            if (!enable) ns = 0;
            else if (m_enq == 0) begin ns = 1; nc = int'(reload_val); end
            else if (m_st == 1) begin
                if (!lv) ns = 2;
                else if (tick) begin
                    if (m_cnt == 0) begin ns = 3; ni = 1; end
                    else nc = m_cnt - 1;
                end
            end else if (m_st == 2 && lv) begin
                ns = 1; nc = int'(reload_val);
            end
            m_st <= ns; m_cnt <= nc; m_irq <= ni;
            m_s2 <= m_s1; m_s1 <= int'(sig_in); m_enq <= int'(enable);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check("R5 count vs model", int'(count), m_cnt);
            check("R8 irq vs model", int'(irq), m_irq);
            check("R6 running vs model", int'(running), (m_st == 1) ? 1 : 0);
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_n(200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        check("R1 count", int'(count), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 running", int'(running), 0);

        // high-valid, settle input
        valid_high = 1'b1; sig_in = 1'b1; reload_val = 16'd3;
        wait_n(3);
        enable = 1'b1;
        wait_n(1);
        check("R2 count", int'(count), 3);
        check("R2 running", int'(running), 1);
        wait_n(3);
        check("R5 hold without tick", int'(count), 3);
        tick = 1'b1; wait_n(1); tick = 1'b0;
        check("R5 single step", int'(count), 2);

        // dropout
        sig_in = 1'b0;
        wait_n(2);
        check("R4 sync latency", int'(running), 1);
        wait_n(1);
        check("R6 paused", int'(running), 0);
        check("R6 count held", int'(count), 2);
        tick = 1'b1; wait_n(4);
        check("R6 ticks ignored while paused", int'(count), 2);

        // return to valid with a new start count
        reload_val = 16'd4; sig_in = 1'b1;
        wait_n(3);
        check("R7 reload count", int'(count), 4);
        check("R7 running", int'(running), 1);
        wait_n(5);
        check("R8 irq", int'(irq), 1);
        check("R8 stopped", int'(running), 0);
        check("R8 count", int'(count), 0);
        wait_n(1);
        check("R11 irq single cycle", int'(irq), 0);
        wait_n(3);
        check("R9 no restart", int'(running), 0);
        check("R9 count stays", int'(count), 0);

        // re-arm
        tick = 1'b0; enable = 1'b0; wait_n(1);
        enable = 1'b1; wait_n(1);
        check("R9 rearm count", int'(count), 4);
        check("R9 rearm running", int'(running), 1);
        enable = 1'b0; wait_n(1);
        check("R10 disabled", int'(running), 0);
        tick = 1'b1; wait_n(5);
        check("R10 count held", int'(count), 4);
        check("R10 no irq", int'(irq), 0);

        // low-valid polarity
        tick = 1'b0; valid_high = 1'b0; sig_in = 1'b0; reload_val = 16'd2;
        wait_n(3);
        enable = 1'b1; wait_n(1);
        check("R3 low-valid armed", int'(count), 2);
        tick = 1'b1; wait_n(2);
        check("R3 low-valid counts", int'(count), 0);
        check("R3 low-valid running", int'(running), 1);
        tick = 1'b0; sig_in = 1'b1; wait_n(3);
        check("R3 high is invalid", int'(running), 0);
        enable = 1'b0; wait_n(2);

        // random stretch, compared per cycle by the model
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 99) < 3) enable = ~enable;
            if ($urandom_range(0, 99) < 10) sig_in = ~sig_in;
            if ($urandom_range(0, 199) == 0) valid_high = ~valid_high;
            if ($urandom_range(0, 49) == 0) reload_val = 16'($urandom_range(0, 12));
            tick = ($urandom_range(0, 2) == 0);
            wait_n(1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule